// File: doc/BRIEF.md
# Vectored priority interrupt controller

This block gathers eight interrupt request lines, keeps a request register and an in-service register, and raises a single interrupt line to the processor when a pending request outranks everything already being serviced. Line 0 has the highest fixed priority and line 7 the lowest.

The processor answers with active-low acknowledge pulses on `ack_n_i`. The block places bytes on an 8-bit bus while a pulse is low, and the `mode_three_i` input picks one of two response styles. In the three-pulse style, the first pulse returns the call opcode 8'hCD and commits the interrupt. The second and third pulses return the low and high bytes of a routine address, equal to `call_base_i` plus four times the level. In the two-pulse style, the first pulse leaves the bus undriven. The second pulse commits the interrupt and returns `{vec_hi_i, level}`. The style is taken when the first pulse of a sequence begins.

In-service bits are cleared either automatically at the end of the last pulse or by a one-cycle `eoi_i` strobe. The strobe clears the highest-priority bit that is set. A request that disappears before the committing pulse is answered as level 7 and marks nothing in service. There is no back-pressure anywhere: the acknowledge pulses pace the bus, and the processor must not start a new sequence before the previous one has ended.

Top module: `vpic_top`

## Requirements
- R1: A request register bit follows its line, sampled on each rising clock edge. When no interrupt is in service, `int_o` is high in the cycle after a line rises.
- R2: When several lines are pending, the committed level is the lowest-numbered pending line.
- R3: `int_o` is high only when some pending line has a lower number than every in-service level. A higher-priority request arriving during service raises it again.
- R4: When `mode_three_i`=1, the data bus carries 8'hCD during pulse 1, bits 7:0 of `call_base_i + 4*level` during pulse 2, and bits 15:8 during pulse 3.
- R5: When `mode_three_i`=0, `data_oe_o` stays 0 during pulse 1, and pulse 2 carries `{vec_hi_i[4:0], level[2:0]}`.
- R6: At the falling edge of the committing pulse (pulse 1 in three-pulse style, pulse 2 in two-pulse style), the level's request bit is cleared and its in-service bit is set. A line still held high therefore no longer raises `int_o`.
- R7: With `auto_eoi_i`=1, the in-service bit is cleared at the rising edge that ends the last pulse. A line still held high raises `int_o` again in the next cycle.
- R8: With `auto_eoi_i`=0, the in-service bit stays set until an `eoi_i` strobe.
- R9: One `eoi_i` strobe clears only the highest-priority set in-service bit.
- R10: If no request is pending at the committing pulse, the response uses level 7 and no in-service bit is set.
- R11: `data_oe_o` is 0 whenever `ack_n_i` is high, and `data_o` reads 0 while `data_oe_o` is 0.
- R12: After reset, `int_o`=0, `data_oe_o`=0, and both registers are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_i | input | 8 | Request lines, active high, line 0 highest priority |
| mode_three_i | input | 1 | 1 = three-pulse style, 0 = two-pulse style |
| auto_eoi_i | input | 1 | 1 = clear in-service bit at end of sequence |
| call_base_i | input | 16 | Base routine address for the three-pulse style |
| vec_hi_i | input | 5 | Upper vector bits for the two-pulse style |
| eoi_i | input | 1 | One-cycle end-of-interrupt strobe |
| ack_n_i | input | 1 | Acknowledge pulse, active low, synchronous to clk |
| int_o | output | 1 | Interrupt request to the processor |
| data_o | output | 8 | Response byte |
| data_oe_o | output | 1 | Bus drive enable for data_o |

## Verification
Bus bytes and the drive enable respond combinationally to `ack_n_i`, so the bench drives each pulse on a falling clock edge and samples one time unit later, inside the same cycle. Commits and automatic clears land on the next rising edge. `int_o` reflects new register state one edge after each line change, pulse edge or `eoi_i` strobe. Every stimulus is therefore applied on a falling edge, and the dependent `int_o` check is made one full cycle later, after the register update. Multi-pulse sequences are walked one pulse at a time, with the bus checked in each pulse and idle checked between pulses.

// File: rtl/vpic_pkg.sv
package vpic_pkg;
  localparam int unsigned LINES      = 8;
  localparam int unsigned BUS_W      = 8;
  localparam int unsigned LVL_W      = $clog2(LINES);
  localparam logic [BUS_W-1:0] CALL_OPCODE = 8'hCD;

  typedef enum logic [1:0] {
    PULSE_ONE   = 2'd0,
    PULSE_TWO   = 2'd1,
    PULSE_THREE = 2'd2
  } pulse_e;
endpackage

// File: rtl/vpic_resolver.sv
module vpic_resolver #(
  parameter int unsigned N  = 8,
  parameter int unsigned LW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic          found_o,
  output logic [LW-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        found_o = 1'b1;
        idx_o   = LW'(i);
      end
    end
  end
endmodule

// File: rtl/vpic_regs.sv
module vpic_regs #(
  parameter int unsigned N  = 8,
  parameter int unsigned LW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  irq_i,
  input  logic          commit_i,
  input  logic          commit_real_i,
  input  logic [LW-1:0] commit_lvl_i,
  input  logic          aeoi_clr_i,
  input  logic [LW-1:0] aeoi_lvl_i,
  input  logic          eoi_i,
  input  logic          top_isr_any_i,
  input  logic [LW-1:0] top_isr_lvl_i,
  output logic [N-1:0]  irr_o,
  output logic [N-1:0]  isr_o
);
  logic [N-1:0] commit_mask, clr_mask, isr_next;

  always_comb begin
    commit_mask = '0;
    clr_mask    = '0;
    if (commit_i && commit_real_i) commit_mask[commit_lvl_i] = 1'b1;
    if (aeoi_clr_i) clr_mask[aeoi_lvl_i] = 1'b1;
    if (eoi_i && top_isr_any_i) clr_mask[top_isr_lvl_i] = 1'b1;
    isr_next = (isr_o & ~clr_mask) | commit_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irr_o <= '0;
      isr_o <= '0;
    end else begin
      irr_o <= irq_i & ~commit_mask;
      isr_o <= isr_next;
    end
  end

  // R6: a real commit leaves its level in service
  a_r6_commit_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_i && commit_real_i && !eoi_i) |=> isr_o[$past(commit_lvl_i)]);

  // R9: a lone EOI strobe removes exactly one in-service bit
  a_r9_eoi_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_i && !commit_i && !aeoi_clr_i && (isr_o != '0))
      |=> ($countones(isr_o) + 1 == $past($countones(isr_o))));
endmodule

// File: rtl/vpic_ack_seq.sv
module vpic_ack_seq
  import vpic_pkg::*;
#(
  parameter int unsigned N         = 8,
  parameter int unsigned LW        = $clog2(N),
  parameter int unsigned DW        = 8,
  parameter int unsigned STEP_LOG2 = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ack_n_i,
  input  logic            three_mode_i,
  input  logic            aeoi_i,
  input  logic [2*DW-1:0] call_base_i,
  input  logic [DW-LW-1:0] vec_hi_i,
  input  logic            pend_found_i,
  input  logic [LW-1:0]   pend_lvl_i,
  output logic [DW-1:0]   data_o,
  output logic            oe_o,
  output logic            commit_o,
  output logic            commit_real_o,
  output logic [LW-1:0]   commit_lvl_o,
  output logic            aeoi_clr_o,
  output logic [LW-1:0]   aeoi_lvl_o
);
  localparam int unsigned AW = 2 * DW;
  localparam logic [LW-1:0] FALLBACK_LVL = LW'(N - 1);

  logic          ack_q, mode_q, real_q;
  logic [LW-1:0] lvl_q;
  pulse_e        pcnt;
  logic          fall, rise, cur_mode, oe_en;
  pulse_e        last_idx, commit_idx;
  logic [LW-1:0] lvl_use;
  logic [AW-1:0] addr;
  logic [DW-1:0] byte_sel;

  assign fall       = ack_q & ~ack_n_i;
  assign rise       = ~ack_q & ack_n_i;
  assign cur_mode   = (fall && pcnt == PULSE_ONE) ? three_mode_i : mode_q;
  assign last_idx   = cur_mode ? PULSE_THREE : PULSE_TWO;
  assign commit_idx = cur_mode ? PULSE_ONE : PULSE_TWO;

  assign commit_o      = fall && (pcnt == commit_idx);
  assign commit_real_o = pend_found_i;
  assign commit_lvl_o  = pend_found_i ? pend_lvl_i : FALLBACK_LVL;
  assign lvl_use       = commit_o ? commit_lvl_o : lvl_q;
  assign addr          = call_base_i + (AW'(lvl_use) << STEP_LOG2);

  assign aeoi_clr_o = rise && (pcnt == last_idx) && aeoi_i && real_q;
  assign aeoi_lvl_o = lvl_q;

  always_comb begin
    oe_en    = 1'b1;
    byte_sel = '0;
    case (pcnt)
      PULSE_ONE: begin
        oe_en    = cur_mode;
        byte_sel = CALL_OPCODE;
      end
      PULSE_TWO:   byte_sel = cur_mode ? addr[DW-1:0] : {vec_hi_i, lvl_use};
      PULSE_THREE: byte_sel = addr[AW-1:DW];
      default:     oe_en = 1'b0;
    endcase
  end

  assign oe_o   = ~ack_n_i & oe_en;
  assign data_o = oe_o ? byte_sel : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q  <= 1'b1;
      mode_q <= 1'b0;
      real_q <= 1'b0;
      lvl_q  <= '0;
      pcnt   <= PULSE_ONE;
    end else begin
      ack_q <= ack_n_i;
      if (fall && pcnt == PULSE_ONE) mode_q <= three_mode_i;
      if (commit_o) begin
        lvl_q  <= commit_lvl_o;
        real_q <= commit_real_o;
      end
      if (rise) pcnt <= (pcnt == last_idx) ? PULSE_ONE : pulse_e'(pcnt + 2'd1);
    end
  end

  // R11: bus is released whenever acknowledge is high
  a_r11_bus_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ack_n_i |-> (!oe_o && data_o == '0));

  // R4: pulse counter never leaves the three legal positions
  a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt != pulse_e'(2'd3));
endmodule

// File: rtl/vpic_top.sv
module vpic_top
  import vpic_pkg::*;
#(
  parameter int unsigned N         = LINES,
  parameter int unsigned DW        = BUS_W,
  parameter int unsigned STEP_LOG2 = 2,
  parameter int unsigned LW        = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    irq_i,
  input  logic            mode_three_i,
  input  logic            auto_eoi_i,
  input  logic [2*DW-1:0] call_base_i,
  input  logic [DW-LW-1:0] vec_hi_i,
  input  logic            eoi_i,
  input  logic            ack_n_i,
  output logic            int_o,
  output logic [DW-1:0]   data_o,
  output logic            data_oe_o
);
  logic [N-1:0]  irr, isr;
  logic          pend_found, isr_found;
  logic [LW-1:0] pend_lvl, isr_lvl;
  logic          commit, commit_real, aeoi_clr;
  logic [LW-1:0] commit_lvl, aeoi_lvl;

  vpic_resolver #(.N(N), .LW(LW)) u_pend_res (
    .req_i(irr), .found_o(pend_found), .idx_o(pend_lvl)
  );

  vpic_resolver #(.N(N), .LW(LW)) u_isr_res (
    .req_i(isr), .found_o(isr_found), .idx_o(isr_lvl)
  );

  vpic_regs #(.N(N), .LW(LW)) u_regs (
    .clk(clk), .rst_n(rst_n), .irq_i(irq_i),
    .commit_i(commit), .commit_real_i(commit_real), .commit_lvl_i(commit_lvl),
    .aeoi_clr_i(aeoi_clr), .aeoi_lvl_i(aeoi_lvl), .eoi_i(eoi_i),
    .top_isr_any_i(isr_found), .top_isr_lvl_i(isr_lvl),
    .irr_o(irr), .isr_o(isr)
  );

  vpic_ack_seq #(.N(N), .LW(LW), .DW(DW), .STEP_LOG2(STEP_LOG2)) u_seq (
    .clk(clk), .rst_n(rst_n), .ack_n_i(ack_n_i),
    .three_mode_i(mode_three_i), .aeoi_i(auto_eoi_i),
    .call_base_i(call_base_i), .vec_hi_i(vec_hi_i),
    .pend_found_i(pend_found), .pend_lvl_i(pend_lvl),
    .data_o(data_o), .oe_o(data_oe_o),
    .commit_o(commit), .commit_real_o(commit_real), .commit_lvl_o(commit_lvl),
    .aeoi_clr_o(aeoi_clr), .aeoi_lvl_o(aeoi_lvl)
  );

  assign int_o = pend_found && (!isr_found || (pend_lvl < isr_lvl));

  // R3: the interrupt line implies something is pending
  a_r3_int_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
    int_o |-> (irr != '0));
endmodule

// File: tb/vpic_top_tb_top.sv
module vpic_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  irq;
  logic        mode3, aeoi, eoi, ack_n;
  logic [15:0] base;
  logic [4:0]  vhi;
  logic        int_w, oe_w;
  logic [7:0]  data_w;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  vpic_top dut_i (
    .clk(clk), .rst_n(rst_n), .irq_i(irq), .mode_three_i(mode3),
    .auto_eoi_i(aeoi), .call_base_i(base), .vec_hi_i(vhi), .eoi_i(eoi),
    .ack_n_i(ack_n), .int_o(int_w), .data_o(data_w), .data_oe_o(oe_w)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic settle();
    @(negedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; irq = '0; mode3 = 1'b0; aeoi = 1'b0; eoi = 1'b0;
    ack_n = 1'b1; base = '0; vhi = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // one acknowledge pulse, two cycles low; checks bus inside the pulse
  task automatic pulse(input string req, input bit exp_oe, input int exp_data);
    @(negedge clk);
    ack_n = 1'b0;
    #1;
    chk(req, oe_w, exp_oe);
    if (exp_oe) chk(req, data_w, exp_data);
    @(negedge clk);
    @(negedge clk);
    ack_n = 1'b1;
    #1;
    chk("R11", oe_w, 0);
  endtask

  task automatic strobe_eoi();
    @(negedge clk);
    eoi = 1'b1;
    @(negedge clk);
    eoi = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    #1;
    chk("R12 int", int_w, 0);
    chk("R12 oe", oe_w, 0);
    chk("R11 data", data_w, 0);
  endtask

  task automatic t_three_aeoi();
    do_reset();
    mode3 = 1'b1; aeoi = 1'b1; base = 16'h1230;
    irq = 8'b0000_0100;
    settle();
    chk("R1 int after line", int_w, 1);
    pulse("R4 opcode", 1'b1, 8'hCD);
    settle();
    chk("R6 int blocked after commit", int_w, 0);
    pulse("R4 low byte", 1'b1, 8'h38);
    pulse("R4 high byte", 1'b1, 8'h12);
    settle();
    chk("R7 int back after auto eoi", int_w, 1);
  endtask

  task automatic t_two_eoi();
    do_reset();
    mode3 = 1'b0; aeoi = 1'b0; vhi = 5'b10101;
    irq = 8'b0010_1000;
    settle();
    chk("R1 int", int_w, 1);
    pulse("R5 silent first", 1'b0, 0);
    pulse("R2 R5 vector", 1'b1, 8'hAB);
    settle();
    chk("R3 lower pending masked", int_w, 0);
    repeat (5) @(negedge clk);
    #1;
    chk("R8 still in service", int_w, 0);
    strobe_eoi();
    #1;
    chk("R8 cleared by eoi", int_w, 1);
  endtask

  task automatic t_nest();
    do_reset();
    mode3 = 1'b0; aeoi = 1'b0; vhi = 5'b00011;
    irq = 8'b0001_0000;
    settle();
    pulse("R5 silent", 1'b0, 0);
    pulse("R5 vector l4", 1'b1, 8'h1C);
    irq = 8'b0001_0010;
    settle();
    chk("R3 nested higher", int_w, 1);
    pulse("R5 silent", 1'b0, 0);
    pulse("R2 vector l1", 1'b1, 8'h19);
    irq = 8'b0100_0000;
    settle();
    chk("R3 two in service", int_w, 0);
    strobe_eoi();
    #1;
    chk("R9 one bit cleared", int_w, 0);
    strobe_eoi();
    #1;
    chk("R9 second clear", int_w, 1);
  endtask

  task automatic t_spurious();
    do_reset();
    mode3 = 1'b1; aeoi = 1'b0; base = 16'h0400;
    irq = 8'b0010_0000;
    settle();
    chk("R1 int", int_w, 1);
    irq = '0;
    settle();
    chk("R1 line dropped", int_w, 0);
    pulse("R10 opcode", 1'b1, 8'hCD);
    pulse("R10 low byte l7", 1'b1, 8'h1C);
    pulse("R10 high byte", 1'b1, 8'h04);
    irq = 8'b1000_0000;
    settle();
    chk("R10 nothing in service", int_w, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_three_aeoi();
    t_two_eoi();
    t_nest();
    t_spurious();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule